// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter clocked by a slow, low-power tick that reaches it as a single-cycle enable pulse in the system clock domain. The tick first passes through a prescaler with two selectable ratios. A postscaler then divides it further by a programmable power of two. When the full period runs out without a restart, the block raises a one-cycle reset request. If the system is in a low-power state at that moment, it raises a one-cycle wake-up pulse instead. Both outcomes also set a sticky timeout flag, which software must clear.

Software restarts the count with a clear strobe. The count also restarts by itself on a power-save entry strobe, on exit from a low-power state and on completion of a clock switch. A windowed mode can be selected. In that mode a clear that arrives too early in the period counts as a violation and forces an immediate reset request.

The watchdog runs whenever the hardware enable is high. When the hardware enable is low, it runs only while the software enable register is set, and reset clears that register.

Top module: `win_watchdog`

## Requirements
- R1: While `rstN` is low and right after it rises, `rstReq`, `wakePulse` and `toFlag` are 0 and the software enable register is 0. With `hwEnable` low and no write to that register, no number of ticks produces a timeout.
- R2: While enabled, a timeout occurs on exactly the 2^(p+s)-th tick after the last restart. Here s is `postSel` (0..15) and p is PRE_LOG_SHORT (default 5, ratio 32) when `preSel`=0, or PRE_LOG_LONG (default 7, ratio 128) when `preSel`=1.
- R3: A timeout with `sleepIdle`=0 drives `rstReq` high for the one cycle that follows the clock edge of the final tick. The count then restarts from zero, so the next timeout needs another full period.
- R4: A timeout with `sleepIdle`=1 drives `wakePulse` high for one cycle with the same timing as R3, and `rstReq` stays 0.
- R5: Every timeout sets `toFlag`. The flag stays set until a `flagClr` strobe, and a timeout in the same cycle as `flagClr` wins, leaving the flag set.
- R6: The count runs when `hwEnable`=1, or when `hwEnable`=0 and the software enable register is 1. A cycle with `swEnWe`=1 loads that register from `swEnData`. While disabled, the count is held at zero and no output fires.
- R7: A strobe on any of `clrWdog` (when no violation occurs), `pwrSave`, `sleepExit` or `clkSwDone` restarts the count from zero.
- R8: When `winDisable`=0 and the watchdog is enabled, a `clrWdog` strobe raises `rstReq` on the next cycle if fewer than T ticks have elapsed since the last restart. With P the full period, T is floor(P/4), floor(P/2), floor(P/2)+floor(P/8) or floor(P/2)+floor(P/4) for `winSel` = 0, 1, 2 or 3. A violation leaves `toFlag` unchanged.
- R9: When `winDisable`=1, or when the watchdog is disabled, `clrWdog` never raises `rstReq`.
- R10: A `clrWdog` in the same cycle as the final tick of a period takes priority. No timeout occurs and a new full period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timebase pulse, one cycle wide |
| hwEnable | input | 1 | Forces the watchdog on |
| swEnWe | input | 1 | Write strobe for the software enable register |
| swEnData | input | 1 | Value loaded into the software enable register |
| clrWdog | input | 1 | Software restart strobe |
| pwrSave | input | 1 | Power-save entry strobe |
| sleepIdle | input | 1 | 1 while the system is in a low-power state |
| sleepExit | input | 1 | Exit from low-power state strobe |
| clkSwDone | input | 1 | Clock switch completed strobe |
| preSel | input | 1 | Prescaler ratio select (0 short, 1 long) |
| postSel | input | POST_SEL_W | Postscaler exponent |
| winDisable | input | 1 | 1 disables windowed clearing |
| winSel | input | 2 | Window opening select |
| flagClr | input | 1 | Clears the sticky timeout flag |
| rstReq | output | 1 | Reset request pulse |
| wakePulse | output | 1 | Wake-up pulse |
| toFlag | output | 1 | Sticky timeout flag |

## Verification
All three outputs come from registers. A timeout or a window violation therefore shows up on the clock edge that samples the final tick or the offending clear strobe, and it lasts only until the next edge. The bench drives every tick and strobe at a falling edge and drops it at the next falling edge. It reads the outputs at that same falling edge, which falls exactly within the one-cycle pulse. The bench computes each period as 2^(p+s) and each window threshold from the floor formulas. It uses a reduced prescaler (ratios 4 and 8) so that it can sweep the postscaler exponents, all four window selects, and both sides of every threshold.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic run;    // counting allowed
    logic clear;  // restart both counters this cycle
  } wdog_strobe_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int PRE_LOG_SHORT = 5,
  parameter int PRE_LOG_LONG  = 7,
  parameter int POST_SEL_W    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  wdog_strobe_t          strb,
  input  logic                  preSel,
  input  logic [POST_SEL_W-1:0] postSel,
  input  logic [1:0]            winSel,
  output logic                  termHit,
  output logic                  earlyZone
);
  localparam int POST_LOG_MAX = (1 << POST_SEL_W) - 1;
  localparam int CNT_W        = PRE_LOG_LONG + POST_LOG_MAX;
  localparam int LOG_W        = $clog2(CNT_W + 1);

  logic [PRE_LOG_LONG-1:0] preCnt, preTop;
  logic [POST_LOG_MAX-1:0] postCnt, postTop;
  logic [LOG_W-1:0]        preLogSel;
  logic                    advance, preAtTop, postAtTop;
  logic [CNT_W-1:0]        elapsed;
  logic [CNT_W:0]          period, threshold;

  assign preLogSel = preSel ? LOG_W'(PRE_LOG_LONG) : LOG_W'(PRE_LOG_SHORT);
  assign preTop    = ~({PRE_LOG_LONG{1'b1}} << preLogSel);
  assign postTop   = ~({POST_LOG_MAX{1'b1}} << postSel);

  // >= keeps a late ratio change from running past the terminal value
  assign preAtTop  = preCnt >= preTop;
  assign postAtTop = postCnt >= postTop;
  assign advance   = tick & strb.run & ~strb.clear;
  assign termHit   = advance & preAtTop & postAtTop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else if (strb.clear) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else if (advance) begin
      if (preAtTop) begin
        preCnt  <= '0;
        postCnt <= postAtTop ? '0 : postCnt + 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end

  // ticks since the last restart, and the window opening point
  assign elapsed = ({{PRE_LOG_LONG{1'b0}}, postCnt} << preLogSel) | CNT_W'(preCnt);
  assign period  = {{CNT_W{1'b0}}, 1'b1} << (preLogSel + LOG_W'(postSel));

  always_comb begin
    unique case (winSel)
      2'd0:    threshold = period >> 2;
      2'd1:    threshold = period >> 1;
      2'd2:    threshold = (period >> 1) + (period >> 3);
      default: threshold = (period >> 1) + (period >> 2);
    endcase
  end

  assign earlyZone = {1'b0, elapsed} < threshold;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hwEnable,
  input  logic         swEnWe,
  input  logic         swEnData,
  input  logic         clrWdog,
  input  logic         pwrSave,
  input  logic         sleepIdle,
  input  logic         sleepExit,
  input  logic         clkSwDone,
  input  logic         winDisable,
  input  logic         flagClr,
  input  logic         termHit,
  input  logic         earlyZone,
  output wdog_strobe_t strb,
  output logic         rstReq,
  output logic         wakePulse,
  output logic         toFlag
);
  logic swEn, enabled, violation;

  assign enabled    = hwEnable | swEn;
  assign strb.run   = enabled;
  assign strb.clear = clrWdog | pwrSave | sleepExit | clkSwDone | ~enabled;
  assign violation  = clrWdog & enabled & ~winDisable & earlyZone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEn      <= 1'b0;
      rstReq    <= 1'b0;
      wakePulse <= 1'b0;
      toFlag    <= 1'b0;
    end else begin
      if (swEnWe) swEn <= swEnData;
      rstReq    <= (termHit & ~sleepIdle) | violation;
      wakePulse <= termHit & sleepIdle;
      if (termHit)      toFlag <= 1'b1;
      else if (flagClr) toFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdog_pkg::*;
#(
  parameter int PRE_LOG_SHORT = 5,
  parameter int PRE_LOG_LONG  = 7,
  parameter int POST_SEL_W    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  hwEnable,
  input  logic                  swEnWe,
  input  logic                  swEnData,
  input  logic                  clrWdog,
  input  logic                  pwrSave,
  input  logic                  sleepIdle,
  input  logic                  sleepExit,
  input  logic                  clkSwDone,
  input  logic                  preSel,
  input  logic [POST_SEL_W-1:0] postSel,
  input  logic                  winDisable,
  input  logic [1:0]            winSel,
  input  logic                  flagClr,
  output logic                  rstReq,
  output logic                  wakePulse,
  output logic                  toFlag
);
  wdog_strobe_t strb;
  logic termHit, earlyZone;

  wdog_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .swEnWe(swEnWe),
    .swEnData(swEnData), .clrWdog(clrWdog), .pwrSave(pwrSave),
    .sleepIdle(sleepIdle), .sleepExit(sleepExit), .clkSwDone(clkSwDone),
    .winDisable(winDisable), .flagClr(flagClr), .termHit(termHit),
    .earlyZone(earlyZone), .strb(strb), .rstReq(rstReq),
    .wakePulse(wakePulse), .toFlag(toFlag)
  );

  wdog_count #(
    .PRE_LOG_SHORT(PRE_LOG_SHORT), .PRE_LOG_LONG(PRE_LOG_LONG),
    .POST_SEL_W(POST_SEL_W)
  ) uCount (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb), .preSel(preSel),
    .postSel(postSel), .winSel(winSel), .termHit(termHit),
    .earlyZone(earlyZone)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic clk,
  input logic rstN,
  input logic clrWdog,
  input logic winDisable,
  input logic flagClr,
  input logic sleepIdle,
  input logic rstReq,
  input logic wakePulse,
  input logic toFlag
);
  // R1
  r1_reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!rstReq && !wakePulse && !toFlag));

  // R4
  wake_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> ($past(sleepIdle) && !rstReq));

  // R4
  wake_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> (rstReq || wakePulse));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toFlag) |-> $past(flagClr));

  // R9
  win_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWdog && winDisable) |=> !rstReq);

  // R10
  clr_no_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWdog |=> !wakePulse);
endmodule

bind win_watchdog wdog_chk uChk (
  .clk(clk), .rstN(rstN), .clrWdog(clrWdog), .winDisable(winDisable),
  .flagClr(flagClr), .sleepIdle(sleepIdle), .rstReq(rstReq),
  .wakePulse(wakePulse), .toFlag(toFlag)
);

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int PS = 2;  // short prescaler log
  localparam int PL = 3;  // long prescaler log

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, hwEnable = 1'b0;
  logic swEnWe = 1'b0, swEnData = 1'b0, clrWdog = 1'b0, pwrSave = 1'b0;
  logic sleepIdle = 1'b0, sleepExit = 1'b0, clkSwDone = 1'b0, preSel = 1'b0;
  logic [3:0] postSel = 4'd0;
  logic winDisable = 1'b1, flagClr = 1'b0;
  logic [1:0] winSel = 2'd0;
  logic rstReq, wakePulse, toFlag;

  int nChk = 0, nBad = 0, rCnt = 0, wCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  win_watchdog #(.PRE_LOG_SHORT(PS), .PRE_LOG_LONG(PL), .POST_SEL_W(4)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .hwEnable(hwEnable), .swEnWe(swEnWe),
    .swEnData(swEnData), .clrWdog(clrWdog), .pwrSave(pwrSave),
    .sleepIdle(sleepIdle), .sleepExit(sleepExit), .clkSwDone(clkSwDone),
    .preSel(preSel), .postSel(postSel), .winDisable(winDisable),
    .winSel(winSel), .flagClr(flagClr), .rstReq(rstReq),
    .wakePulse(wakePulse), .toFlag(toFlag)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic sampleOut();
    if (rstReq) rCnt++;
    if (wakePulse) wCnt++;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      sampleOut();
    end
  endtask

  // 0 clr, 1 pwrSave, 2 sleepExit, 3 clkSwDone, 4 flagClr, 5 swEn on, 6 swEn off
  task automatic fire(input int which);
    @(negedge clk);
    case (which)
      0: clrWdog = 1'b1;
      1: pwrSave = 1'b1;
      2: sleepExit = 1'b1;
      3: clkSwDone = 1'b1;
      4: flagClr = 1'b1;
      5: begin swEnWe = 1'b1; swEnData = 1'b1; end
      default: begin swEnWe = 1'b1; swEnData = 1'b0; end
    endcase
    @(negedge clk);
    clrWdog = 1'b0; pwrSave = 1'b0; sleepExit = 1'b0; clkSwDone = 1'b0;
    flagClr = 1'b0; swEnWe = 1'b0; swEnData = 1'b0;
    sampleOut();
  endtask

  function automatic int periodOf(input int pre, input int post);
    return 1 << ((pre ? PL : PS) + post);
  endfunction

  // expects silence for P-1 ticks, then exactly one reset request
  task automatic checkPeriod(input string tag, input int p);
    rCnt = 0; wCnt = 0;
    tickN(p - 1);
    chk({tag, " early"}, rCnt, 0);
    tickN(1);
    chk({tag, " at period"}, rCnt, 1);
    chk({tag, " no wake"}, wCnt, 0);
  endtask

  initial begin
    int p, thr;
    repeat (3) @(negedge clk);
    chk("R1 rstReq in reset", int'(rstReq), 0);
    chk("R1 flag in reset", int'(toFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 wake after reset", int'(wakePulse), 0);
    rCnt = 0; wCnt = 0;
    tickN(2 * periodOf(0, 1));
    chk("R1 swEn cleared, no timeout", rCnt + wCnt, 0);

    // R2 R3 R5: sweep prescaler and postscaler
    hwEnable = 1'b1;
    for (int pr = 0; pr < 2; pr++) begin
      for (int ps = 0; ps < 6; ps++) begin
        preSel = pr[0]; postSel = 4'(ps);
        fire(3);
        checkPeriod($sformatf("R2 pre%0d post%0d", pr, ps), periodOf(pr, ps));
        chk("R5 flag set", int'(toFlag), 1);
        @(negedge clk);
        chk("R3 pulse one cycle", int'(rstReq), 0);
        fire(4);
        chk("R5 flag cleared", int'(toFlag), 0);
      end
    end

    // R3: restart after timeout, back-to-back periods
    preSel = 1'b0; postSel = 4'd2; fire(3);
    p = periodOf(0, 2);
    checkPeriod("R3 first", p);
    checkPeriod("R3 restart", p);
    repeat (5) @(negedge clk);
    chk("R5 flag sticky", int'(toFlag), 1);
    fire(4);

    // R5: timeout wins over a simultaneous flagClr
    tickN(p - 1);
    @(negedge clk) begin tick = 1'b1; flagClr = 1'b1; end
    @(negedge clk) begin tick = 1'b0; flagClr = 1'b0; end
    chk("R5 set beats clear", int'(toFlag), 1);
    fire(4);

    // R4: wake instead of reset
    sleepIdle = 1'b1; fire(3);
    rCnt = 0; wCnt = 0;
    tickN(p);
    chk("R4 wake pulse", wCnt, 1);
    chk("R4 no reset", rCnt, 0);
    chk("R4 flag set", int'(toFlag), 1);
    sleepIdle = 1'b0; fire(4);

    // R6: software enable
    hwEnable = 1'b0; fire(6);
    rCnt = 0;
    tickN(2 * p);
    chk("R6 disabled silent", rCnt, 0);
    fire(5);
    checkPeriod("R6 sw enabled", p);
    tickN(p / 2);
    fire(6); fire(5);
    checkPeriod("R6 re-enable restarts", p);
    fire(6); hwEnable = 1'b1;

    // R7: restart events
    for (int ev = 0; ev < 4; ev++) begin
      fire(3);
      tickN(p - 1);
      rCnt = 0;
      fire(ev);
      checkPeriod($sformatf("R7 event %0d", ev), p);
    end
    fire(4);

    // R8: window thresholds, both sides
    winDisable = 1'b0; preSel = 1'b0;
    for (int ps = 2; ps < 4; ps++) begin
      for (int ws = 0; ws < 4; ws++) begin
        postSel = 4'(ps); winSel = 2'(ws);
        p = periodOf(0, ps);
        case (ws)
          0: thr = p / 4;
          1: thr = p / 2;
          2: thr = p / 2 + p / 8;
          default: thr = p / 2 + p / 4;
        endcase
        for (int e = thr - 1; e <= thr; e++) begin
          fire(3);
          rCnt = 0;
          tickN(e);
          fire(0);
          chk($sformatf("R8 post%0d win%0d e%0d", ps, ws, e), rCnt, (e < thr) ? 1 : 0);
          chk("R8 flag untouched", int'(toFlag), 0);
        end
      end
    end

    // R9: window off, or watchdog disabled
    winDisable = 1'b1; fire(3);
    rCnt = 0; fire(0);
    chk("R9 window disabled", rCnt, 0);
    winDisable = 1'b0; hwEnable = 1'b0;
    rCnt = 0; fire(0);
    chk("R9 disabled watchdog", rCnt, 0);

    // R10: clear coinciding with final tick
    hwEnable = 1'b1; winDisable = 1'b1; postSel = 4'd2; fire(3);
    p = periodOf(0, 2);
    tickN(p - 1);
    @(negedge clk) begin tick = 1'b1; clrWdog = 1'b1; end
    @(negedge clk) begin tick = 1'b0; clrWdog = 1'b0; end
    chk("R10 clear wins", int'(rstReq), 0);
    checkPeriod("R10 new period", p);

    done = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule